// File: doc/BRIEF.md
# Programmable LCD panel timing generator

This block produces the raster timing for an LCD panel from a set of configuration inputs. It divides the system clock into pixel periods, counts pixels across each line and lines across each frame, and from those counts drives horizontal sync, vertical sync, a data-valid (output-enable) strobe, a pixel clock, and the coordinates of the pixel being shown. A single-cycle start-of-frame pulse tells a downstream fetch unit that a new frame has begun.

Configuration is presented on plain input buses and captured by a one-cycle load strobe into a pending copy. The pending copy moves into the working copy only at the end of a frame, so one frame never mixes two settings. Horizontal fields and the vertical sync and active fields hold their length minus one. The two vertical porch fields hold exact line counts, so zero removes that porch. Each output's polarity is programmable, and so is the pixel clock edge.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line is ordered as sync, back porch, active and front porch. Their lengths in pixels are `cfg_hsw`+1, `cfg_hbp`+1, `cfg_hact`+1 and `cfg_hfp`+1. Horizontal sync is asserted for the first `cfg_hsw`+1 pixels of every line, and the next frame starts right after the last pixel of the last line.
- R2: The horizontal active window starts at pixel `cfg_hsw`+`cfg_hbp`+2 of the line and lasts `cfg_hact`+1 pixels. Inside the window `px_x` counts 0 to `cfg_hact`. Outside the active area `px_x` and `px_y` are 0.
- R3: A frame is ordered as `cfg_vsw`+1 sync lines, `cfg_vbp` back-porch lines, `cfg_vact`+1 active lines and `cfg_vfp` front-porch lines. A porch value of zero gives no porch lines. Inside the active lines `px_y` counts 0 to `cfg_vact`.
- R4: `cfg_hs_pol` and `cfg_vs_pol` set the level of the asserted sync: 1 drives the sync high while asserted and low otherwise, and 0 does the reverse.
- R5: The data-valid strobe `de_o` is asserted only where both the horizontal and the vertical windows are active. Its asserted level is `cfg_de_pol` (1 = high, 0 = low).
- R6: With `cfg_pclk_pol`=1 the panel samples on the rising edge: `pclk_o` is low in the first half of each pixel period and high in the second half. With 0 it is the inverse. All other outputs change only at the start of a pixel period, on the opposite edge from the sampling edge.
- R7: With `cfg_dbl_pclk`=0 a pixel period is 4 system clocks. With 1 it is 2 system clocks.
- R8: A pulse on `cfg_load` captures all configuration inputs. They take effect at the start of the next frame, and the frame in progress keeps its settings. Changes on the configuration inputs without `cfg_load` have no effect.
- R9: `sof_o` is high for exactly one system clock, the first clock of line 0, pixel 0 of each frame.
- R10: Reset returns the counters to the first clock of a frame and clears both configuration copies to zero. While reset is held, `sof_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for the configuration inputs |
| cfg_hact | input | HW | Active pixels per line minus one |
| cfg_hsw | input | HW | Horizontal sync width minus one |
| cfg_hbp | input | HW | Horizontal back porch minus one |
| cfg_hfp | input | HW | Horizontal front porch minus one |
| cfg_vact | input | VW | Active lines per frame minus one |
| cfg_vsw | input | VW | Vertical sync width minus one |
| cfg_vbp | input | VW | Vertical back porch, exact lines |
| cfg_vfp | input | VW | Vertical front porch, exact lines |
| cfg_hs_pol | input | 1 | Horizontal sync asserted level |
| cfg_vs_pol | input | 1 | Vertical sync asserted level |
| cfg_de_pol | input | 1 | Data-valid asserted level |
| cfg_pclk_pol | input | 1 | Panel sampling edge, 1 = rising |
| cfg_dbl_pclk | input | 1 | Pixel period of 2 clocks instead of 4 |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-valid strobe |
| sof_o | output | 1 | Start-of-frame pulse |
| px_x | output | HW | Active pixel column |
| px_y | output | VW | Active line row |

## Verification
Every output is decoded from the phase, pixel and line registers alone. A result therefore appears in the same clock as the counter state that produces it. The bench samples at the falling edge and numbers each clock from the falling edge where `sof_o` is seen. For clock k the expected values come from k: pixel = k / period, phase = k mod period, then line and column from the line total. A loaded configuration is due at the first start of frame after the capturing clock edge. The bench therefore checks the frame in which the load happens against the old settings, the following frame against the new ones, and expects `sof_o` again exactly one frame length later.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hsw,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hfp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vsw,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vfp,
  input  logic          cfg_hs_pol,
  input  logic          cfg_vs_pol,
  input  logic          cfg_de_pol,
  input  logic          cfg_pclk_pol,
  input  logic          cfg_dbl_pclk,
  output logic          pclk_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          sof_o,
  output logic [HW-1:0] px_x,
  output logic [VW-1:0] px_y
);
  localparam int HCW = HW + 3;
  localparam int VCW = VW + 3;
  localparam int CW  = 4 * HW + 4 * VW + 5;

  logic [CW-1:0] pend, act;
  logic [HW-1:0] a_hact, a_hsw, a_hbp, a_hfp;
  logic [VW-1:0] a_vact, a_vsw, a_vbp, a_vfp;
  logic          a_hs_pol, a_vs_pol, a_de_pol, a_pc_pol, a_dbl;

  assign {a_hact, a_hsw, a_hbp, a_hfp, a_vact, a_vsw, a_vbp, a_vfp,
          a_hs_pol, a_vs_pol, a_de_pol, a_pc_pol, a_dbl} = act;

  logic [1:0]     ph;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;

  logic [HCW-1:0] h_sw_end, h_act_beg, h_act_end, h_last;
  logic [VCW-1:0] v_sw_end, v_act_beg, v_act_end, v_last;

  assign h_sw_end  = HCW'(a_hsw) + HCW'(1);
  assign h_act_beg = h_sw_end + HCW'(a_hbp) + HCW'(1);
  assign h_act_end = h_act_beg + HCW'(a_hact) + HCW'(1);
  assign h_last    = h_act_end + HCW'(a_hfp);
  assign v_sw_end  = VCW'(a_vsw) + VCW'(1);
  assign v_act_beg = v_sw_end + VCW'(a_vbp);
  assign v_act_end = v_act_beg + VCW'(a_vact) + VCW'(1);
  assign v_last    = v_act_end + VCW'(a_vfp) - VCW'(1);

  logic tick, line_end, frame_end, h_on, v_on, on, half;

  assign tick      = (ph == (a_dbl ? 2'd1 : 2'd3));
  assign line_end  = tick && (hcnt == h_last);
  assign frame_end = line_end && (vcnt == v_last);
  assign h_on      = (hcnt >= h_act_beg) && (hcnt < h_act_end);
  assign v_on      = (vcnt >= v_act_beg) && (vcnt < v_act_end);
  assign on        = h_on && v_on;
  assign half      = a_dbl ? ph[0] : ph[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      hcnt <= '0;
      vcnt <= '0;
      pend <= '0;
      act  <= '0;
    end else begin
      ph <= tick ? 2'd0 : ph + 2'd1;
      if (tick) hcnt <= line_end ? '0 : hcnt + HCW'(1);
      if (line_end) vcnt <= frame_end ? '0 : vcnt + VCW'(1);
      if (cfg_load) pend <= {cfg_hact, cfg_hsw, cfg_hbp, cfg_hfp,
                             cfg_vact, cfg_vsw, cfg_vbp, cfg_vfp,
                             cfg_hs_pol, cfg_vs_pol, cfg_de_pol,
                             cfg_pclk_pol, cfg_dbl_pclk};
      if (frame_end) act <= pend;
    end
  end

  assign pclk_o  = a_pc_pol ? half : ~half;
  assign hsync_o = (hcnt < h_sw_end) ? a_hs_pol : ~a_hs_pol;
  assign vsync_o = (vcnt < v_sw_end) ? a_vs_pol : ~a_vs_pol;
  assign de_o    = on ? a_de_pol : ~a_de_pol;
  assign sof_o   = rst_n && (hcnt == '0) && (vcnt == '0) && (ph == 2'd0);
  assign px_x    = on ? HW'(hcnt - h_act_beg) : '0;
  assign px_y    = on ? VW'(vcnt - v_act_beg) : '0;

  // R1: the pixel counter never runs past the programmed line total
  a_r1_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= h_last);

  // R3: the line counter never runs past the programmed frame total
  a_r3_v_bound: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt <= v_last);

  // R7: the pixel position holds for the whole pixel period
  a_r7_hold_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hcnt));

  // R8: the working configuration changes only at a frame origin
  a_r8_swap_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) |-> (hcnt == '0 && vcnt == '0 && ph == 2'd0));

  // R9: a frame begins inside both sync pulses
  a_r9_sof_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> (hsync_o == a_hs_pol && vsync_o == a_vs_pol));

  // R2: the reported column stays inside the active width
  a_r2_x_range: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o == a_de_pol) |-> (px_x <= a_hact));
endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
  localparam int HW = 10;
  localparam int VW = 10;

  typedef struct {
    int hact, hsw, hbp, hfp, vact, vsw, vbp, vfp, hsp, vsp, dep, pcp, dbl;
  } cfg_t;

  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0;
  logic [HW-1:0] cfg_hact = '0, cfg_hsw = '0, cfg_hbp = '0, cfg_hfp = '0;
  logic [VW-1:0] cfg_vact = '0, cfg_vsw = '0, cfg_vbp = '0, cfg_vfp = '0;
  logic cfg_hs_pol = 1'b0, cfg_vs_pol = 1'b0, cfg_de_pol = 1'b0;
  logic cfg_pclk_pol = 1'b0, cfg_dbl_pclk = 1'b0;
  logic pclk_o, hsync_o, vsync_o, de_o, sof_o;
  logic [HW-1:0] px_x;
  logic [VW-1:0] px_y;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lcd_timing_gen #(.HW(HW), .VW(VW)) u_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_hact(cfg_hact), .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp),
    .cfg_vact(cfg_vact), .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_de_pol(cfg_de_pol),
    .cfg_pclk_pol(cfg_pclk_pol), .cfg_dbl_pclk(cfg_dbl_pclk),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .sof_o(sof_o), .px_x(px_x), .px_y(px_y)
  );

  function automatic cfg_t mk(int hact, int hsw, int hbp, int hfp, int vact, int vsw,
                              int vbp, int vfp, int hsp, int vsp, int dep, int pcp, int dbl);
    cfg_t c;
    c.hact = hact; c.hsw = hsw; c.hbp = hbp; c.hfp = hfp;
    c.vact = vact; c.vsw = vsw; c.vbp = vbp; c.vfp = vfp;
    c.hsp = hsp; c.vsp = vsp; c.dep = dep; c.pcp = pcp; c.dbl = dbl;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic cmp(inout int cnt, inout int fa, inout int fe, input int a, input int e);
    if (a != e) begin
      if (cnt == 0) begin fa = a; fe = e; end
      cnt++;
    end
  endtask

  task automatic drive(input cfg_t c);
    cfg_hact = HW'(c.hact); cfg_hsw = HW'(c.hsw); cfg_hbp = HW'(c.hbp); cfg_hfp = HW'(c.hfp);
    cfg_vact = VW'(c.vact); cfg_vsw = VW'(c.vsw); cfg_vbp = VW'(c.vbp); cfg_vfp = VW'(c.vfp);
    cfg_hs_pol = c.hsp[0]; cfg_vs_pol = c.vsp[0]; cfg_de_pol = c.dep[0];
    cfg_pclk_pol = c.pcp[0]; cfg_dbl_pclk = c.dbl[0];
  endtask

  // R8: present a configuration with a one-clock capture strobe
  task automatic load_cfg(input cfg_t c);
    drive(c);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_sof();
    for (int i = 0; i < 5000 && !sof_o; i++) @(negedge clk);
    if (!sof_o) check(1'b0, "R9 start of frame never seen", 0, 1);
  endtask

  // Checks one whole frame clock by clock against config c, optionally
  // loading nc mid-frame (R8) and then leaving gc on the inputs unloaded.
  task automatic run_frame(input cfg_t c, input bit do_load, input cfg_t nc, input cfg_t gc);
    int div, ht, vt, ft;
    int eh = 0, ev = 0, ed = 0, ex = 0, ey = 0, ep = 0, es = 0;
    int ah = 0, xh = 0, av = 0, xv = 0, ad = 0, xd = 0, ax = 0, xx = 0;
    int ay = 0, xy = 0, ap = 0, xp = 0, as = 0, xs = 0;
    wait_sof();
    div = c.dbl ? 2 : 4;
    ht = c.hsw + c.hbp + c.hact + c.hfp + 4;
    vt = c.vsw + c.vbp + c.vact + c.vfp + 2;
    ft = div * ht * vt;
    for (int k = 0; k < ft; k++) begin
      int p, phs, h, v, hb, vb, e_x, e_y;
      bit hon, von, on, half;
      p = k / div; phs = k % div; h = p % ht; v = p / ht;
      hb = c.hsw + c.hbp + 2; vb = c.vsw + 1 + c.vbp;
      hon = (h >= hb) && (h < hb + c.hact + 1);
      von = (v >= vb) && (v < vb + c.vact + 1);
      on = hon && von;
      half = (phs >= div / 2);
      e_x = on ? h - hb : 0;
      e_y = on ? v - vb : 0;
      cmp(eh, ah, xh, int'(hsync_o), (h < c.hsw + 1) ? c.hsp : 1 - c.hsp);
      cmp(ev, av, xv, int'(vsync_o), (v < c.vsw + 1) ? c.vsp : 1 - c.vsp);
      cmp(ed, ad, xd, int'(de_o), on ? c.dep : 1 - c.dep);
      cmp(ex, ax, xx, int'(px_x), e_x);
      cmp(ey, ay, xy, int'(px_y), e_y);
      cmp(ep, ap, xp, int'(pclk_o), c.pcp != 0 ? int'(half) : int'(!half));
      cmp(es, as, xs, int'(sof_o), (k == 0) ? 1 : 0);
      if (do_load && k == 37) begin drive(nc); cfg_load = 1'b1; end
      if (do_load && k == 38) begin cfg_load = 1'b0; drive(gc); end
      @(negedge clk);
    end
    check(eh == 0, "R1 R4 hsync", ah, xh);
    check(ev == 0, "R3 R4 vsync", av, xv);
    check(ed == 0, "R5 data valid", ad, xd);
    check(ex == 0, "R2 px_x", ax, xx);
    check(ey == 0, "R3 px_y", ay, xy);
    check(ep == 0, "R6 R7 pixel clock", ap, xp);
    check(es == 0, "R9 single start pulse", as, xs);
    check(sof_o == 1'b1, "R1 R3 frame length", int'(sof_o), 1);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sof_o == 1'b0, "R10 sof low in reset", int'(sof_o), 0);
    check(hsync_o == 1'b0, "R10 hsync in reset", int'(hsync_o), 0);
    check(vsync_o == 1'b0, "R10 vsync in reset", int'(vsync_o), 0);
    check(de_o == 1'b1, "R10 data valid idle in reset", int'(de_o), 1);
    check(px_x == '0, "R10 px_x in reset", int'(px_x), 0);
    rst_n = 1'b1;
    #1;
    check(sof_o == 1'b1, "R9 R10 frame origin after reset", int'(sof_o), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_t z, a, b, g, c;
    z = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    a = mk(7, 1, 1, 2, 3, 0, 2, 1, 0, 1, 1, 1, 0);
    b = mk(3, 2, 0, 0, 2, 1, 0, 0, 1, 0, 0, 0, 1);
    g = mk(1, 0, 5, 0, 1, 0, 3, 3, 0, 1, 1, 1, 0);
    c = mk(4, 0, 3, 0, 0, 2, 0, 3, 1, 1, 0, 0, 0);
    @(negedge clk);
    test_reset();
    run_frame(z, 1'b0, z, z);
    load_cfg(a);
    run_frame(a, 1'b1, b, g);
    run_frame(b, 1'b0, z, z);
    run_frame(b, 1'b0, z, z);
    load_cfg(c);
    run_frame(c, 1'b0, z, z);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule